// File: doc/BRIEF.md
# Packed-Decimal Shift-and-Round Unit

This unit moves the magnitude of a 31-digit signed packed-decimal number left or right by whole decimal digits. A second 128-bit operand carries the signed digit count. Right shifts round half-up using the last digit that falls off the low end. Left shifts report whether any significant digit was lost off the high end. The sign nibble of the result is rebuilt in a preferred form. A four-bit condition code reports how the result compares with zero. Operands that are not legal packed decimal produce only the overflow/invalid flag and leave the previous result standing.

The unit is one register stage deep. A request is presented with `in_valid`, and the result appears with `out_valid` on the next cycle. There is no back-pressure, and a new request may be accepted on every cycle.

Top module: `bcd_shift_round_unit`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle in which `in_valid` was high, and is low otherwise.
- R2: The count is the signed 8-bit field at bits [71:64] of `shift_src`, and every other bit of `shift_src` is ignored. Counts above 31 act as 31, and counts below -31 act as -31.
- R3: A positive count moves the digits toward the most significant end and fills with zeros. Condition bit 0 (overflow) is set when any nonzero digit is pushed out.
- R4: A negative count moves the digits toward the least significant end. When the last digit pushed out is 5 or more, one is added to the lowest digit, with decimal carry into higher digits.
- R5: A zero count leaves every digit unchanged, with no rounding and no overflow.
- R6: The input sign codes 0xB and 0xD mean negative and give result sign 0xD. The codes 0xA, 0xC, 0xE and 0xF mean positive and give 0xC when `pos_alt_sel`=0 and 0xF when it is 1.
- R7: The condition code is {lt, gt, eq, ov} at bits 3..0. A result with all digits zero sets only eq (plus ov if raised), whatever its sign. Otherwise a negative result sets lt and a positive one sets gt.
- R8: If any digit of `operand` exceeds 9, or its sign nibble (bits [3:0]) is 0x0 to 0x9, then `cond` is 4'b0001 and `result` keeps its previous value.
- R9: After reset, `result`, `cond` and `out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| operand | input | 128 | Packed-decimal source; digits in [127:4], sign in [3:0] |
| shift_src | input | 128 | Holds the signed digit count in [71:64] |
| pos_alt_sel | input | 1 | Selects the alternative positive sign code |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| result | output | 128 | Shifted, rounded packed-decimal result |
| cond | output | 4 | {lt, gt, eq, ov} |

## Verification
Two functions can meet in one cycle: overflow detection on a left shift, and the comparison against zero. A clamped count of 100 applied to a value of one pushes its only digit out. The result is therefore zero with overflow, and the bench expects eq and ov together with lt and gt clear. Rounding and the zero compare also meet when a maximal right shift empties the magnitude and the rounding then makes it nonzero. In that case gt must replace eq.

// File: rtl/bcdsr_pkg.sv
`timescale 1ns/1ps
package bcdsr_pkg;
    localparam int NDIG    = 31;
    localparam int MAGW    = NDIG * 4;
    localparam int WORDW   = MAGW + 4;
    localparam int CNTW    = 8;
    localparam int CNT_LSB = WORDW - 64;

    typedef logic [3:0]      nib_t;
    typedef logic [MAGW-1:0] mag_t;

    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic ov;
    } cc_t;

    typedef struct packed {
        mag_t mag;
        logic ov;
        logic round_up;
    } shift_res_t;

    function automatic logic is_sign_code(nib_t n);
        return n >= 4'hA;
    endfunction

    function automatic logic is_minus(nib_t n);
        return (n == 4'hB) || (n == 4'hD);
    endfunction

    function automatic nib_t pick_sign(logic minus, logic alt);
        if (minus)
            return 4'hD;
        return alt ? 4'hF : 4'hC;
    endfunction
endpackage

// File: rtl/bcdsr_validate.sv
`timescale 1ns/1ps
module bcdsr_validate
    import bcdsr_pkg::*;
#(
    parameter int DIGITS = NDIG
) (
    input  logic [DIGITS*4+3:0] word,
    output logic                legal
);
    logic [DIGITS-1:0] bad_digit;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        assign bad_digit[g] = word[4*g+4 +: 4] > 4'd9;
    end

    assign legal = ~|bad_digit && is_sign_code(word[3:0]);
endmodule

// File: rtl/bcdsr_shifter.sv
`timescale 1ns/1ps
module bcdsr_shifter
    import bcdsr_pkg::*;
#(
    parameter int DIGITS = NDIG,
    parameter int CW     = CNTW
) (
    input  logic [DIGITS*4-1:0]   mag_in,
    input  logic signed [CW-1:0]  count,
    output logic [DIGITS*4-1:0]   mag_out,
    output logic                  lost,
    output logic                  round_up
);
    localparam int W    = DIGITS * 4;
    localparam int AMTW = $clog2(DIGITS + 1);

    logic          go_left;
    logic          go_right;
    logic [AMTW-1:0] amt;
    logic [2*W-1:0] wide_l;
    logic [2*W-1:0] wide_r;

    always_comb begin
        go_left  = count > 0;
        go_right = count < 0;
        if (count > DIGITS)
            amt = AMTW'(DIGITS);
        else if (count < -DIGITS)
            amt = AMTW'(DIGITS);
        else if (go_right)
            amt = AMTW'(-count);
        else
            amt = AMTW'(count);

        wide_l = {{W{1'b0}}, mag_in} << (4 * int'(amt));
        wide_r = {mag_in, {W{1'b0}}} >> (4 * int'(amt));

        if (go_left) begin
            mag_out  = wide_l[W-1:0];
            lost     = |wide_l[2*W-1:W];
            round_up = 1'b0;
        end else if (go_right) begin
            mag_out  = wide_r[2*W-1:W];
            lost     = 1'b0;
            round_up = wide_r[W-1 -: 4] >= 4'd5;
        end else begin
            mag_out  = mag_in;
            lost     = 1'b0;
            round_up = 1'b0;
        end
    end
endmodule

// File: rtl/bcdsr_incr.sv
`timescale 1ns/1ps
module bcdsr_incr
    import bcdsr_pkg::*;
#(
    parameter int DIGITS = NDIG
) (
    input  logic [DIGITS*4-1:0] mag_in,
    input  logic                inc,
    output logic [DIGITS*4-1:0] mag_out
);
    logic [DIGITS:0] carry;
    assign carry[0] = inc;

    for (genvar g = 0; g < DIGITS; g++) begin : g_dig
        logic [3:0] d;
        assign d = mag_in[4*g +: 4];
        always_comb begin
            if (carry[g] && d == 4'd9) begin
                mag_out[4*g +: 4] = 4'd0;
                carry[g+1]        = 1'b1;
            end else begin
                mag_out[4*g +: 4] = d + {3'd0, carry[g]};
                carry[g+1]        = 1'b0;
            end
        end
    end
endmodule

// File: rtl/bcd_shift_round_unit.sv
`timescale 1ns/1ps
module bcd_shift_round_unit
    import bcdsr_pkg::*;
#(
    parameter int DIGITS = NDIG
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    input  logic [DIGITS*4+3:0] operand,
    input  logic [DIGITS*4+3:0] shift_src,
    input  logic                pos_alt_sel,
    output logic                out_valid,
    output logic [DIGITS*4+3:0] result,
    output logic [3:0]          cond
);
    localparam int W    = DIGITS * 4;
    localparam int WW   = W + 4;
    localparam int CLSB = WW - 64;

    logic                 in_ok;
    logic [W-1:0]         shifted;
    logic [W-1:0]         rounded;
    logic                 lost;
    logic                 round_up;
    logic signed [CNTW-1:0] count;
    cc_t                  cc_next;
    nib_t                 sign_next;

    assign count = shift_src[CLSB +: CNTW];

    bcdsr_validate #(.DIGITS(DIGITS)) u_val (
        .word  (operand),
        .legal (in_ok)
    );

    bcdsr_shifter #(.DIGITS(DIGITS), .CW(CNTW)) u_shf (
        .mag_in   (operand[WW-1:4]),
        .count    (count),
        .mag_out  (shifted),
        .lost     (lost),
        .round_up (round_up)
    );

    bcdsr_incr #(.DIGITS(DIGITS)) u_inc (
        .mag_in  (shifted),
        .inc     (round_up),
        .mag_out (rounded)
    );

    always_comb begin
        sign_next  = pick_sign(is_minus(operand[3:0]), pos_alt_sel);
        cc_next    = '0;
        cc_next.ov = lost;
        if (rounded == '0)
            cc_next.eq = 1'b1;
        else if (is_minus(operand[3:0]))
            cc_next.lt = 1'b1;
        else
            cc_next.gt = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            cond      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                if (in_ok) begin
                    result <= {rounded, sign_next};
                    cond   <= cc_next;
                end else begin
                    cond   <= 4'b0001;
                end
            end
        end
    end

    AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R1
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid); // R1
    AST_INVALID_FLAG_ONLY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_ok) |=> (cond == 4'b0001 && $stable(result))); // R8
    AST_REL_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $onehot0(cond[3:1])); // R7
    AST_ZERO_EQ: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cond[1]) |-> (result[WW-1:4] == '0)); // R7
    AST_NEG_SIGN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cond[3]) |-> (result[3:0] == 4'hD)); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ok && count <= 0) |=> !cond[0]); // R3
endmodule

// File: tb/bcd_shift_round_unit_test.sv
`timescale 1ns/1ps
module bcd_shift_round_unit_test;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] operand = '0;
    logic [127:0] shift_src = '0;
    logic         pos_alt_sel = 1'b0;
    logic         out_valid;
    logic [127:0] result;
    logic [3:0]   cond;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    bcd_shift_round_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .operand(operand),
        .shift_src(shift_src), .pos_alt_sel(pos_alt_sel),
        .out_valid(out_valid), .result(result), .cond(cond)
    );

    task automatic check(string req, logic [131:0] act, logic [131:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Count operand with junk everywhere except the count byte (R2).
    function automatic logic [127:0] cnt_word(logic [7:0] c);
        return {56'hA5A5_A5A5_A5A5_A5, c, 64'hFFFF_FFFF_FFFF_FFFF};
    endfunction

    task automatic apply(string req, logic [123:0] mag, logic [3:0] sgn,
                         logic [7:0] c, logic sel,
                         logic [127:0] exp_res, logic [3:0] exp_cc);
        @(negedge clk);
        operand     = {mag, sgn};
        shift_src   = cnt_word(c);
        pos_alt_sel = sel;
        in_valid    = 1'b1;
        @(negedge clk);
        in_valid    = 1'b0;
        check({req, " R1 valid"}, {131'd0, out_valid}, 132'd1);
        check({req, " result"}, {4'd0, result}, {4'd0, exp_res});
        check({req, " cond"}, {128'd0, cond}, {128'd0, exp_cc});
        @(negedge clk);
        check({req, " R1 drop"}, {131'd0, out_valid}, 132'd0);
    endtask

    task automatic t_reset;
        check("R9 reset", {3'd0, out_valid, result}, 132'd0);
        check("R9 reset cond", {128'd0, cond}, 132'd0);
    endtask

    task automatic t_left;
        apply("R3 left2", 124'h123, 4'hC, 8'd2, 1'b0, {124'h12300, 4'hC}, 4'b0100);
    endtask

    task automatic t_right_trunc;
        apply("R4 right2 no round", 124'h12345, 4'hD, 8'hFE, 1'b0, {124'h123, 4'hD}, 4'b1000);
    endtask

    task automatic t_right_carry;
        apply("R4 R6 right1 carry", 124'h1999, 4'hA, 8'hFF, 1'b1, {124'h200, 4'hF}, 4'b0100);
    endtask

    task automatic t_round_from_zero;
        apply("R4 right3 digit0", 124'h5000, 4'hC, 8'hFD, 1'b0, {124'h5, 4'hC}, 4'b0100);
        apply("R4 right4 round", 124'h5000, 4'hC, 8'hFC, 1'b0, {124'h1, 4'hC}, 4'b0100);
    endtask

    task automatic t_zero_count;
        apply("R5 zero count", 124'h987, 4'hE, 8'd0, 1'b0, {124'h987, 4'hC}, 4'b0100);
    endtask

    task automatic t_left_overflow;
        logic [123:0] m = (124'h7 << 120) | 124'h5;
        apply("R3 lost digit", m, 4'hC, 8'd1, 1'b0, {124'h50, 4'hC}, 4'b0101);
    endtask

    task automatic t_clamp_left;
        apply("R2 R7 clamp +100", 124'h1, 4'hB, 8'd100, 1'b0, {124'h0, 4'hD}, 4'b0011);
    endtask

    task automatic t_clamp_right;
        apply("R2 clamp -128", 124'h6 << 120, 4'hC, 8'h80, 1'b1, {124'h1, 4'hF}, 4'b0100);
    endtask

    task automatic t_neg_zero;
        apply("R7 negative zero", 124'h0, 4'hD, 8'd0, 1'b0, {124'h0, 4'hD}, 4'b0010);
    endtask

    task automatic t_invalid;
        logic [127:0] keep;
        apply("R6 prep", 124'h42, 4'hF, 8'd0, 1'b1, {124'h42, 4'hF}, 4'b0100);
        keep = {124'h42, 4'hF};
        apply("R8 bad digit", 124'hA1, 4'hC, 8'd1, 1'b0, keep, 4'b0001);
        apply("R8 bad sign", 124'h1, 4'h3, 8'd1, 1'b0, keep, 4'b0001);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_left();
        t_right_trunc();
        t_right_carry();
        t_round_from_zero();
        t_zero_count();
        t_left_overflow();
        t_clamp_left();
        t_clamp_right();
        t_neg_zero();
        t_invalid();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule